// File: doc/BRIEF.md
# MII Management Master with Periodic PHY Polling

This block is the management-side master for an external Ethernet PHY. It drives a divided management clock (MDC) and a bidirectional data line (MDIO, split into output, output-enable and input pins) and runs clause 22 read and write frames when software sets a command bit. Software supplies the register address and write data. It gets back the read data, a done flag, and command bits that clear themselves once their frame has finished.

The same frame engine can also poll PHY register 1 on its own. The gap between polls is counted in MDC cycles and is picked from four lengths. During polling the clock can optionally run four times faster. The link-status bit of each polled value is compared with the previous sample, and any change raises a one-cycle pulse. A sticky error flag records coding errors that the PHY reports on its receive-error line.

Top module: `mdio_poll_engine`

## Requirements
- R1: A write frame is 64 MDC cycles, sent MSB first: 32 ones, start `01`, opcode `01`, 5-bit PHY address, 5-bit register address, turnaround `10`, then 16 data bits. The output enable is high for all 64 bits.
- R2: A read frame uses opcode `10`. The output enable drops for the two turnaround bits and all 16 data bits. MDIO input is sampled on each rising MDC edge of the data bits, and the 16 samples, MSB first, appear on `rd_data` once the frame completes.
- R3: `rd_go`/`wr_go` set `rd_cmd`/`wr_cmd` and clear `done`. When the frame ends, the command bit clears and `done` is set in the same cycle. If both command bits are pending, the read goes first.
- R4: The PHY address register resets to `00001` and is loaded from `phy_wdata` when `phy_we` is high. Every frame carries its value.
- R5: While `phy_opt` is high, frames carry PHY address `00001` whatever the register holds.
- R6: Software frames always run MDC with a high phase and a low phase of `MDC_HALF` clock cycles each.
- R7: Poll frames read register 1. With `fast_mdc` high, their MDC phases last `MDC_HALF/4` clocks. With it low, the phases last `MDC_HALF` clocks.
- R8: Between consecutive poll frames the engine waits a gap of 1024, 512, 128 or 64 MDC cycles, for `poll_sel` = 0, 1, 2 or 3 respectively. Polling starts at once when `poll_en` rises.
- R9: After each poll frame, bit 2 of the polled value is compared with the previous sample (0 after reset). A difference gives a one-cycle `link_chg` pulse, and `link_up` follows the new sample.
- R10: A software command issued while a poll frame is running waits for that frame to end and then runs next.
- R11: `err_flag` is set the cycle after `rx_er` is high and stays set. `err_clr` clears it, but a simultaneous `rx_er` keeps it set.
- R12: When no frame is running, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_go | input | 1 | Pulse: request a read frame |
| wr_go | input | 1 | Pulse: request a write frame |
| reg_addr | input | 5 | PHY register address for software frames |
| wr_data | input | 16 | Data for write frames |
| phy_we | input | 1 | Load the PHY address register |
| phy_wdata | input | 5 | New PHY address |
| phy_opt | input | 1 | Force PHY address 00001 |
| poll_en | input | 1 | Enable periodic polling |
| poll_sel | input | 2 | Poll gap select |
| fast_mdc | input | 1 | Quadruple MDC rate for poll frames |
| rx_er | input | 1 | PHY receive coding error |
| err_clr | input | 1 | Clear the error flag |
| mdio_i | input | 1 | MDIO input from the pad |
| rd_cmd | output | 1 | Read command pending |
| wr_cmd | output | 1 | Write command pending |
| done | output | 1 | Last software frame finished |
| rd_data | output | 16 | Data of the last software read |
| link_up | output | 1 | Last polled link status |
| link_chg | output | 1 | One-cycle link change pulse |
| err_flag | output | 1 | Sticky coding error flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The hardest case to reach is a software command that arrives while a poll frame is already on the wire. The bench selects the longest poll gap with the fast clock, enables polling so that a poll frame starts at once, and issues a read partway through it. The frame log then has to show the poll frame finishing at the fast rate, followed by the software read at the normal rate, with no other frame between them. Gap lengths are measured from the last falling MDC edge of one poll frame to the first rising edge of the next.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [1:0] {KIND_NONE, KIND_RD, KIND_WR, KIND_POLL} xfer_kind_e;

  localparam int FRAME_BITS = 64;
  localparam int TA_POS = 46;
  localparam int DATA_POS = 48;
  localparam int GAP_W = 11;
  localparam logic [4:0] PHY_ADDR_DEFAULT = 5'b00001;
  localparam logic [4:0] POLL_REG = 5'd1;
  localparam int LINK_BIT = 2;

  function automatic logic [GAP_W-1:0] gap_cycles(input logic [1:0] sel);
    case (sel)
      2'd0: gap_cycles = 11'd1024;
      2'd1: gap_cycles = 11'd512;
      2'd2: gap_cycles = 11'd128;
      default: gap_cycles = 11'd64;
    endcase
  endfunction
endpackage

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame #(
  parameter int HALF_NORM = 8,
  parameter int HALF_FAST = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        fast,
  input  logic        is_read,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  import mdio_pkg::*;
  localparam int HW = $clog2(HALF_NORM) + 1;

  logic [FRAME_BITS-1:0] frm;
  logic [5:0]            bitn;
  logic [5:0]            nxt;
  logic [HW-1:0]         hcnt, hlim;
  logic                  rd_q;

  assign nxt = bitn + 6'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; mdc <= 1'b0;
      mdio_o <= 1'b0; mdio_oe <= 1'b0;
      frm <= '0; bitn <= '0; hcnt <= '0; hlim <= '0;
      rd_q <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        mdc <= 1'b0;
        if (start) begin
          busy <= 1'b1;
          frm <= {32'hFFFF_FFFF, 2'b01, (is_read ? 2'b10 : 2'b01), phy, regad,
                  2'b10, (is_read ? 16'h0000 : wdata)};
          bitn <= '0;
          hcnt <= '0;
          hlim <= fast ? HW'(HALF_FAST - 1) : HW'(HALF_NORM - 1);
          rd_q <= is_read;
          mdio_o <= 1'b1;
          mdio_oe <= 1'b1;
        end
      end else if (hcnt == hlim) begin
        hcnt <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (rd_q && bitn >= 6'(DATA_POS))
            rdata <= {rdata[14:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (bitn == 6'(FRAME_BITS - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o <= 1'b0;
          end else begin
            bitn <= nxt;
            mdio_o <= frm[~nxt];
            mdio_oe <= !(rd_q && nxt >= 6'(TA_POS));
          end
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_poll_sched.sv
`timescale 1ns/1ps
module mdio_poll_sched #(
  parameter int HALF_NORM = 8,
  parameter int HALF_FAST = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       poll_en,
  input  logic [1:0] sel,
  input  logic       fast,
  input  logic       poll_done,
  output logic       due
);
  import mdio_pkg::*;
  localparam int PW = $clog2(2 * HALF_NORM) + 1;

  logic [GAP_W-1:0] gap_cnt;
  logic [PW-1:0]    pre, plim;

  assign plim = fast ? PW'(2 * HALF_FAST - 1) : PW'(2 * HALF_NORM - 1);
  assign due  = poll_en && (gap_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !poll_en) begin
      gap_cnt <= '0;
      pre <= '0;
    end else if (poll_done) begin
      gap_cnt <= gap_cycles(sel);
      pre <= '0;
    end else if (gap_cnt != '0) begin
      if (pre == plim) begin
        pre <= '0;
        gap_cnt <= gap_cnt - GAP_W'(1);
      end else begin
        pre <= pre + PW'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_link_track.sv
`timescale 1ns/1ps
module mdio_link_track (
  input  logic        clk,
  input  logic        rst,
  input  logic        poll_done,
  input  logic [15:0] poll_data,
  output logic        link_up,
  output logic        link_chg
);
  import mdio_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_up <= 1'b0;
      link_chg <= 1'b0;
    end else if (poll_done) begin
      link_chg <= poll_data[LINK_BIT] != link_up;
      link_up <= poll_data[LINK_BIT];
    end else begin
      link_chg <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_poll_engine.sv
`timescale 1ns/1ps
module mdio_poll_engine #(
  parameter int MDC_HALF = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_go,
  input  logic        wr_go,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        phy_we,
  input  logic [4:0]  phy_wdata,
  input  logic        phy_opt,
  input  logic        poll_en,
  input  logic [1:0]  poll_sel,
  input  logic        fast_mdc,
  input  logic        rx_er,
  input  logic        err_clr,
  input  logic        mdio_i,
  output logic        rd_cmd,
  output logic        wr_cmd,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        link_up,
  output logic        link_chg,
  output logic        err_flag,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  import mdio_pkg::*;
  localparam int HALF_FAST = (MDC_HALF / 4 > 0) ? MDC_HALF / 4 : 1;

  xfer_kind_e  next_kind, cur_kind;
  logic        fr_busy, fr_done, fr_start, poll_due, poll_done;
  logic [15:0] fr_rdata;
  logic [4:0]  phy_addr_q, phy_eff, fr_reg;

  assign next_kind = rd_cmd ? KIND_RD : (wr_cmd ? KIND_WR : KIND_POLL);
  assign fr_start  = !fr_busy && !fr_done && (rd_cmd || wr_cmd || poll_due);
  assign phy_eff   = phy_opt ? PHY_ADDR_DEFAULT : phy_addr_q;
  assign fr_reg    = (next_kind == KIND_POLL) ? POLL_REG : reg_addr;
  assign poll_done = fr_done && (cur_kind == KIND_POLL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_kind <= KIND_NONE;
      rd_cmd <= 1'b0; wr_cmd <= 1'b0; done <= 1'b0;
      rd_data <= '0; phy_addr_q <= PHY_ADDR_DEFAULT; err_flag <= 1'b0;
    end else begin
      if (fr_start) cur_kind <= next_kind;

      if (rd_go) rd_cmd <= 1'b1;
      else if (fr_done && cur_kind == KIND_RD) rd_cmd <= 1'b0;

      if (wr_go) wr_cmd <= 1'b1;
      else if (fr_done && cur_kind == KIND_WR) wr_cmd <= 1'b0;

      if (rd_go || wr_go) done <= 1'b0;
      else if (fr_done && cur_kind != KIND_POLL) done <= 1'b1;

      if (fr_done && cur_kind == KIND_RD) rd_data <= fr_rdata;

      if (phy_we) phy_addr_q <= phy_wdata;

      if (rx_er) err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end

  mdio_frame #(.HALF_NORM(MDC_HALF), .HALF_FAST(HALF_FAST)) u_frame (
    .clk(clk), .rst(rst), .start(fr_start),
    .fast(next_kind == KIND_POLL && fast_mdc),
    .is_read(next_kind != KIND_WR), .phy(phy_eff), .regad(fr_reg),
    .wdata(wr_data), .mdio_i(mdio_i), .busy(fr_busy), .done(fr_done),
    .rdata(fr_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_poll_sched #(.HALF_NORM(MDC_HALF), .HALF_FAST(HALF_FAST)) u_sched (
    .clk(clk), .rst(rst), .poll_en(poll_en), .sel(poll_sel),
    .fast(fast_mdc), .poll_done(poll_done), .due(poll_due)
  );

  mdio_link_track u_link (
    .clk(clk), .rst(rst), .poll_done(poll_done), .poll_data(fr_rdata),
    .link_up(link_up), .link_chg(link_chg)
  );
endmodule

// File: rtl/mdio_poll_chk.sv
`timescale 1ns/1ps
module mdio_poll_chk (
  input logic clk,
  input logic rst,
  input logic rx_er,
  input logic err_clr,
  input logic err_flag,
  input logic link_chg,
  input logic done,
  input logic rd_cmd,
  input logic wr_cmd,
  input logic mdc,
  input logic mdio_oe,
  input logic fr_busy
);
  // R11
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_er |=> err_flag);
  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !rx_er) |=> !err_flag);
  // R9
  link_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    link_chg |=> !link_chg);
  // R3
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($fell(rd_cmd) || $fell(wr_cmd)));
  // R12
  idle_mdc_chk: assert property (@(posedge clk) disable iff (rst)
    !fr_busy |-> !mdc);
  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !fr_busy |-> !mdio_oe);
endmodule

bind mdio_poll_engine mdio_poll_chk u_chk (
  .clk(clk), .rst(rst), .rx_er(rx_er), .err_clr(err_clr), .err_flag(err_flag),
  .link_chg(link_chg), .done(done), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
  .mdc(mdc), .mdio_oe(mdio_oe), .fr_busy(fr_busy)
);

// File: tb/test_mdio_poll_engine.sv
`timescale 1ns/1ps
module test_mdio_poll_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_go = 0, wr_go = 0, phy_we = 0, phy_opt = 0, poll_en = 0;
  logic fast_mdc = 0, rx_er = 0, err_clr = 0;
  logic [4:0] reg_addr = '0, phy_wdata = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] poll_sel = '0;
  logic mdio_i_r = 1'b1;
  logic rd_cmd, wr_cmd, done, link_up, link_chg, err_flag, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  int errors = 0, checks = 0;
  logic [15:0] phy_reg1 = 16'h0000;

  always #5 clk = ~clk;

  mdio_poll_engine i_mdio_poll_engine (
    .clk(clk), .rst(rst), .rd_go(rd_go), .wr_go(wr_go), .reg_addr(reg_addr),
    .wr_data(wr_data), .phy_we(phy_we), .phy_wdata(phy_wdata), .phy_opt(phy_opt),
    .poll_en(poll_en), .poll_sel(poll_sel), .fast_mdc(fast_mdc), .rx_er(rx_er),
    .err_clr(err_clr), .mdio_i(mdio_i_r), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .done(done), .rd_data(rd_data), .link_up(link_up), .link_chg(link_chg),
    .err_flag(err_flag), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // PHY model and frame monitor
  logic [63:0] cap_v = '0, cap_oe = '0;
  logic [63:0] log_v [0:63];
  logic [63:0] log_oe [0:63];
  int log_hi [0:63];
  int nfr = 0, mcnt = 0, last_hi = 0, last_gap = 0;
  longint t_rise = 0, t_end = 0;

  function automatic logic [15:0] phy_resp(input logic [4:0] ra);
    phy_resp = (ra == 5'd1) ? phy_reg1 : (16'hA5C3 ^ {11'd0, ra});
  endfunction

  always @(posedge mdc) begin
    logic [15:0] rv;
    cap_v[63-mcnt] = mdio_o;
    cap_oe[63-mcnt] = mdio_oe;
    if (mcnt == 0) last_gap = int'(($time - t_end) / 10);
    t_rise = $time;
    mcnt = mcnt + 1;
    rv = phy_resp(cap_v[22:18]);
    if (mcnt >= 48 && mcnt < 64) mdio_i_r = rv[15-(mcnt-48)];
    else mdio_i_r = 1'b1;
    if (mcnt == 64) begin
      log_v[nfr % 64] = cap_v;
      log_oe[nfr % 64] = cap_oe;
      log_hi[nfr % 64] = last_hi;
      nfr = nfr + 1;
      mcnt = 0;
    end
  end

  always @(negedge mdc) begin
    last_hi = int'(($time - t_rise) / 10);
    if (mcnt == 0) t_end = $time;
  end

  int lpulses = 0, lrun = 0, lmax = 0;
  always @(negedge clk) begin
    if (link_chg) begin
      lpulses = lpulses + 1;
      lrun = lrun + 1;
      if (lrun > lmax) lmax = lrun;
    end else lrun = 0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
  endtask

  task automatic wait_frames(input int target);
    for (int i = 0; i < 30000 && nfr < target; i++) @(negedge clk);
  endtask

  task automatic stop_poll();
    poll_en = 0;
    clks(1200);
  endtask

  task automatic t_reset();
    clks(3);
    rst = 0;
    clks(2);
    chk(!rd_cmd && !wr_cmd && !done, "R3", "cmd/done after reset", {rd_cmd, wr_cmd, done}, 0);
    chk(!mdc && !mdio_oe, "R12", "mdc/oe after reset", {mdc, mdio_oe}, 0);
    chk(!err_flag && !link_up && !link_chg, "R9", "flags after reset",
        {err_flag, link_up, link_chg}, 0);
  endtask

  task automatic t_write();
    int n0 = nfr;
    logic [63:0] ev;
    reg_addr = 5'd9; wr_data = 16'h3C5A;
    wr_go = 1; clks(1); wr_go = 0;
    chk(wr_cmd && !done, "R3", "write pending", {wr_cmd, done}, 2);
    wait_done();
    chk(done && !wr_cmd, "R3", "write self-clear", {wr_cmd, done}, 1);
    ev = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, 5'd9, 2'b10, 16'h3C5A};
    chk(nfr == n0 + 1 && log_v[n0 % 64] == ev, "R1", "write frame bits", log_v[n0 % 64], ev);
    chk(log_oe[n0 % 64] == '1, "R1", "write frame oe", log_oe[n0 % 64], 64'hFFFF_FFFF_FFFF_FFFF);
    chk(log_hi[n0 % 64] == 8, "R6", "sw mdc half", log_hi[n0 % 64], 8);
    clks(40);
    chk(!mdc && !mdio_oe && nfr == n0 + 1, "R12", "idle after write", {mdc, mdio_oe}, 0);
  endtask

  task automatic sw_read(input logic [4:0] ra, output logic [63:0] v);
    int n0 = nfr;
    reg_addr = ra;
    rd_go = 1; clks(1); rd_go = 0;
    chk(rd_cmd && !done, "R3", "read pending / done cleared", {rd_cmd, done}, 2);
    wait_done();
    chk(done && !rd_cmd, "R3", "read self-clear", {rd_cmd, done}, 1);
    v = log_v[n0 % 64];
    chk(log_oe[n0 % 64] == {{46{1'b1}}, 18'd0}, "R2", "read turnaround release",
        log_oe[n0 % 64], {{46{1'b1}}, 18'd0});
    chk(v[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, v[27:23], ra}, "R2", "read header",
        v[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, v[27:23], ra});
    chk(rd_data == (16'hA5C3 ^ {11'd0, ra}), "R2", "read data", rd_data,
        16'hA5C3 ^ {11'd0, ra});
  endtask

  task automatic t_phyaddr();
    logic [63:0] v;
    sw_read(5'd5, v);
    chk(v[27:23] == 5'd1, "R4", "default phy addr", v[27:23], 1);
    phy_wdata = 5'h13; phy_we = 1; clks(1); phy_we = 0;
    sw_read(5'd2, v);
    chk(v[27:23] == 5'h13, "R4", "written phy addr", v[27:23], 5'h13);
    phy_opt = 1;
    sw_read(5'd3, v);
    chk(v[27:23] == 5'd1, "R5", "forced phy addr", v[27:23], 1);
    phy_opt = 0;
  endtask

  task automatic t_both();
    int n0 = nfr;
    reg_addr = 5'd6; wr_data = 16'h1234;
    rd_go = 1; wr_go = 1; clks(1); rd_go = 0; wr_go = 0;
    wait_frames(n0 + 2);
    wait_done();
    chk(log_v[n0 % 64][29:28] == 2'b10 && log_v[(n0 + 1) % 64][29:28] == 2'b01, "R3",
        "read before write", {log_v[n0 % 64][29:28], log_v[(n0 + 1) % 64][29:28]}, 4'b1001);
  endtask

  task automatic t_err();
    rx_er = 1; clks(1); rx_er = 0;
    chk(err_flag, "R11", "error set", err_flag, 1);
    clks(5);
    chk(err_flag, "R11", "error sticky", err_flag, 1);
    err_clr = 1; clks(1); err_clr = 0;
    chk(!err_flag, "R11", "error cleared", err_flag, 0);
    err_clr = 1; rx_er = 1; clks(1); err_clr = 0; rx_er = 0;
    chk(err_flag, "R11", "set wins over clear", err_flag, 1);
    err_clr = 1; clks(1); err_clr = 0;
  endtask

  task automatic t_gap(input logic [1:0] sel, input bit fast, input int gcyc);
    int n0 = nfr;
    int h = fast ? 2 : 8;
    int base = gcyc * 2 * h + h;
    logic [63:0] v;
    poll_sel = sel; fast_mdc = fast; poll_en = 1;
    wait_frames(n0 + 2);
    v = log_v[(n0 + 1) % 64];
    chk(last_gap >= base && last_gap <= base + 6, "R8", "poll gap", last_gap, base);
    chk(v[29:28] == 2'b10 && v[22:18] == 5'd1, "R7", "poll reads reg 1", v[22:18], 1);
    chk(log_hi[(n0 + 1) % 64] == h, "R7", "poll mdc half", log_hi[(n0 + 1) % 64], h);
    stop_poll();
  endtask

  task automatic t_wait_poll();
    int n0 = nfr;
    poll_sel = 2'd0; fast_mdc = 1; poll_en = 1;
    clks(60);
    chk(nfr == n0 && mdc !== 1'bx, "R10", "poll frame in progress", nfr, n0);
    reg_addr = 5'd7;
    rd_go = 1; clks(1); rd_go = 0;
    clks(20);
    chk(rd_cmd && nfr == n0, "R10", "sw read held", rd_cmd, 1);
    wait_done();
    chk(nfr == n0 + 2, "R10", "frame count", nfr, n0 + 2);
    chk(log_v[n0 % 64][22:18] == 5'd1 && log_hi[n0 % 64] == 2, "R10", "poll frame first",
        log_v[n0 % 64][22:18], 1);
    chk(log_v[(n0 + 1) % 64][22:18] == 5'd7 && log_hi[(n0 + 1) % 64] == 8, "R6",
        "sw frame normal rate after poll", log_hi[(n0 + 1) % 64], 8);
    chk(rd_data == 16'hA5C4, "R10", "read data after wait", rd_data, 16'hA5C4);
    stop_poll();
  endtask

  task automatic t_link();
    int n0 = nfr;
    int p0 = lpulses;
    phy_reg1 = 16'h0004;
    poll_sel = 2'd3; fast_mdc = 0; poll_en = 1;
    wait_frames(n0 + 1); clks(30);
    chk(lpulses == p0 + 1 && link_up, "R9", "link up pulse", lpulses - p0, 1);
    wait_frames(n0 + 2); clks(30);
    chk(lpulses == p0 + 1, "R9", "no pulse when same", lpulses - p0, 1);
    phy_reg1 = 16'hFFFB;
    wait_frames(n0 + 3); clks(30);
    chk(lpulses == p0 + 2 && !link_up, "R9", "link down pulse", lpulses - p0, 2);
    chk(lmax == 1, "R9", "pulse width", lmax, 1);
    stop_poll();
  endtask

  bit finished = 0;
  initial begin
    #(64'd200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write();
    t_phyaddr();
    t_both();
    t_err();
    t_gap(2'd3, 1'b0, 64);
    t_gap(2'd2, 1'b0, 128);
    t_gap(2'd3, 1'b1, 64);
    t_gap(2'd1, 1'b1, 512);
    t_gap(2'd0, 1'b1, 1024);
    t_wait_poll();
    t_link();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule